// File: doc/BRIEF.md
# Interrupt Enable and Halt Controller

This block holds the maskable-interrupt state of a small 8-bit processor core. It keeps a master enable flag and a shadow copy of it. It also keeps a deferred-enable countdown that starts after an enable-interrupts instruction, a halted (sleep) flag, and the memory-refresh register. The decoder around it reports each completed instruction step with a one-cycle strobe. Alongside that strobe it asserts a pulse for any enable-interrupts, disable-interrupts or halt instruction that the step executed.

The interrupt request line is sampled only at step boundaries. The block decides whether the request wakes a sleeping core, is accepted or is merely noted. An accepted request produces a one-cycle accept pulse together with a request to push the program counter. While the core sleeps, the block raises a fetch-inhibit signal that tells the sequencer to fetch nothing and to leave the program counter alone. Each sleeping step still counts as a step.

Top module: `irq_gate_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both enable flags, the deferred-enable countdown, the halted flag, the accept pulse and the whole refresh register (value 0x00).
- R2: An enable-interrupts step loads a countdown of 2. The countdown drops by one on every step boundary, including the loading step. Both enable flags rise together at the boundary where it reaches zero, which is the end of the step after the enable step. Clock cycles without a step strobe do not count.
- R3: A disable-interrupts step clears both enable flags at its own boundary and zeroes the countdown, so an earlier pending enable never takes effect.
- R4: A halt step sets the halted flag. While halted, fetch_inhibit is high and the enable, disable, halt and refresh-load pulses are ignored.
- R5: The countdown advances on the halt step and on halted steps just as on executed steps. An enable step followed directly by a halt step raises both flags at the halt boundary, with halted high.
- R6: A request sampled at a step boundary clears the halted flag whether or not interrupts are enabled. This includes a halt step completing at that same boundary.
- R7: A request at a boundary where the master flag is clear produces no accept pulse and leaves the enable flags unchanged.
- R8: A request at a boundary where the master flag was already set is accepted. irq_accept and push_pc are then high for exactly one clock after that boundary, both enable flags clear, and the countdown is zeroed.
- R9: On each step boundary the low 7 bits of refresh increment modulo 128 while bit 7 keeps its value. A refresh-load pulse on a non-halted step instead writes all 8 bits from r_wdata.
- R10: The request has no effect in clock cycles without a step strobe.
- R11: If reset and a request arrive in the same cycle, reset wins and no accept pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_done | input | 1 | One-cycle strobe marking the end of an instruction step |
| op_ei | input | 1 | The completing step executed enable-interrupts |
| op_di | input | 1 | The completing step executed disable-interrupts |
| op_halt | input | 1 | The completing step executed halt |
| irq_req | input | 1 | Maskable interrupt request level |
| r_load | input | 1 | The completing step writes the refresh register |
| r_wdata | input | R_W | Value written to the refresh register |
| ien_master | output | 1 | Master interrupt enable |
| ien_shadow | output | 1 | Shadow copy of the interrupt enable |
| halted | output | 1 | Core is sleeping |
| fetch_inhibit | output | 1 | Sequencer must skip opcode fetch and hold the program counter |
| irq_accept | output | 1 | One-cycle pulse: interrupt taken |
| push_pc | output | 1 | One-cycle request to push the current program counter |
| refresh | output | R_W | Refresh register |

## Verification
Two collisions at the same step boundary matter most. The first is a request landing on the boundary where the deferred enable expires. The bench schedules an enable step followed by a step carrying the request. It expects the flags to rise with no accept, and the request held into the next step to be taken there. The second is a request landing on the same boundary as a halt step, where the bench expects the core to stay awake. Reset coinciding with a request is also driven. The random phase mixes all of these freely, and a reference model built from the requirements judges every cycle.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  // Instruction effect reported with a step strobe, after priority decode
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_EI   = 2'd1,
    OP_DI   = 2'd2,
    OP_HALT = 2'd3
  } step_op_e;

  localparam int unsigned EI_DELAY_DEFAULT = 2;
  localparam int unsigned REFRESH_W_DEFAULT = 8;
  localparam int unsigned REFRESH_CNT_W_DEFAULT = 7;

endpackage

// File: rtl/irq_ei_countdown.sv
module irq_ei_countdown #(
  parameter int unsigned DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic load,
  input  logic cancel,
  output logic expire
);
  localparam int unsigned CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
  // The loading step already consumes one tick
  localparam logic [CW-1:0] RELOAD = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;

  always_comb begin
    expire = 1'b0;
    if (step && !cancel) begin
      if (load) expire = (DELAY == 1);
      else      expire = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (step) begin
      if (cancel)              cnt_q <= '0;
      else if (load)           cnt_q <= RELOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/irq_halt_state.sv
module irq_halt_state (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic enter,
  input  logic wake,
  output logic halted_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
    end else if (step) begin
      if (wake)       halted_q <= 1'b0;
      else if (enter) halted_q <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_refresh_ctr.sv
module irq_refresh_ctr #(
  parameter int unsigned R_W   = 8,
  parameter int unsigned CNT_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           load,
  input  logic [R_W-1:0] wdata,
  output logic [R_W-1:0] value_q
);

  generate
    if (CNT_W < R_W) begin : g_split
      always_ff @(posedge clk) begin
        if (rst) begin
          value_q <= '0;
        end else if (step) begin
          if (load) value_q <= wdata;
          else      value_q <= {value_q[R_W-1:CNT_W], value_q[CNT_W-1:0] + CNT_W'(1)};
        end
      end
    end else begin : g_full
      always_ff @(posedge clk) begin
        if (rst) begin
          value_q <= '0;
        end else if (step) begin
          if (load) value_q <= wdata;
          else      value_q <= value_q + R_W'(1);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int unsigned EI_DELAY = EI_DELAY_DEFAULT,
  parameter int unsigned R_W      = REFRESH_W_DEFAULT,
  parameter int unsigned R_CNT_W  = REFRESH_CNT_W_DEFAULT
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_done,
  input  logic           op_ei,
  input  logic           op_di,
  input  logic           op_halt,
  input  logic           irq_req,
  input  logic           r_load,
  input  logic [R_W-1:0] r_wdata,
  output logic           ien_master,
  output logic           ien_shadow,
  output logic           halted,
  output logic           fetch_inhibit,
  output logic           irq_accept,
  output logic           push_pc,
  output logic [R_W-1:0] refresh
);

  step_op_e op;
  logic     halt_q;
  logic     exec;
  logic     take;
  logic     expire;
  logic     mst_q;
  logic     shd_q;
  logic     acc_q;

  assign exec = step_done && !halt_q;

  // Disable outranks enable, enable outranks halt
  always_comb begin
    op = OP_NONE;
    if (exec) begin
      if (op_di)        op = OP_DI;
      else if (op_ei)   op = OP_EI;
      else if (op_halt) op = OP_HALT;
    end
  end

  // Acceptance uses the flag as it stood before this boundary
  assign take = step_done && irq_req && mst_q;

  irq_ei_countdown #(.DELAY(EI_DELAY)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .step   (step_done),
    .load   (op == OP_EI),
    .cancel (take || (op == OP_DI)),
    .expire (expire)
  );

  irq_halt_state u_halt (
    .clk      (clk),
    .rst      (rst),
    .step     (step_done),
    .enter    (op == OP_HALT),
    .wake     (irq_req),
    .halted_q (halt_q)
  );

  irq_refresh_ctr #(.R_W(R_W), .CNT_W(R_CNT_W)) u_refresh (
    .clk     (clk),
    .rst     (rst),
    .step    (step_done),
    .load    (exec && r_load),
    .wdata   (r_wdata),
    .value_q (refresh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_q <= 1'b0;
      shd_q <= 1'b0;
    end else if (step_done) begin
      if (take || (op == OP_DI)) begin
        mst_q <= 1'b0;
        shd_q <= 1'b0;
      end else if (expire) begin
        mst_q <= 1'b1;
        shd_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= 1'b0;
    else     acc_q <= take;
  end

  assign ien_master    = mst_q;
  assign ien_shadow    = shd_q;
  assign halted        = halt_q;
  assign fetch_inhibit = halt_q;
  assign irq_accept    = acc_q;
  assign push_pc       = acc_q;

endmodule

// File: rtl/irq_gate_ctrl_chk.sv
module irq_gate_ctrl_chk #(
  parameter int unsigned R_W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           step_done,
  input logic           op_di,
  input logic           op_halt,
  input logic           irq_req,
  input logic           r_load,
  input logic           ien_master,
  input logic           ien_shadow,
  input logic           halted,
  input logic           fetch_inhibit,
  input logic           irq_accept,
  input logic           push_pc,
  input logic [R_W-1:0] refresh
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!ien_master && !ien_shadow && !halted && !irq_accept && refresh == '0));

  assert_flags_pair_R2: assert property (@(posedge clk) disable iff (rst)
    ien_master == ien_shadow);

  assert_enable_on_step_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ien_master) |-> $past(step_done));

  assert_di_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (step_done && op_di && !halted) |=> !ien_master);

  assert_halt_enters_R4: assert property (@(posedge clk) disable iff (rst)
    (step_done && op_halt && !op_di && !halted && !irq_req) |=> halted);

  assert_inhibit_tracks_R4: assert property (@(posedge clk) disable iff (rst)
    fetch_inhibit == halted);

  assert_wake_R6: assert property (@(posedge clk) disable iff (rst)
    (step_done && irq_req) |=> !halted);

  assert_masked_no_take_R7: assert property (@(posedge clk) disable iff (rst)
    (step_done && irq_req && !ien_master) |=> !irq_accept);

  assert_accept_cause_R8: assert property (@(posedge clk) disable iff (rst)
    irq_accept |-> ($past(ien_master) && $past(irq_req) && $past(step_done)));

  assert_accept_single_R8: assert property (@(posedge clk) disable iff (rst)
    irq_accept |=> !irq_accept);

  assert_push_with_accept_R8: assert property (@(posedge clk) disable iff (rst)
    push_pc == irq_accept);

  assert_refresh_top_R9: assert property (@(posedge clk) disable iff (rst)
    (step_done && (!r_load || halted)) |=> $stable(refresh[R_W-1]));

  assert_no_step_no_take_R10: assert property (@(posedge clk) disable iff (rst)
    !step_done |=> !irq_accept);

  assert_reset_beats_irq_R11: assert property (@(posedge clk)
    (rst && irq_req) |=> !irq_accept);

endmodule

bind irq_gate_ctrl irq_gate_ctrl_chk #(.R_W(R_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .step_done     (step_done),
  .op_di         (op_di),
  .op_halt       (op_halt),
  .irq_req       (irq_req),
  .r_load        (r_load),
  .ien_master    (ien_master),
  .ien_shadow    (ien_shadow),
  .halted        (halted),
  .fetch_inhibit (fetch_inhibit),
  .irq_accept    (irq_accept),
  .push_pc       (push_pc),
  .refresh       (refresh)
);

// File: tb/irq_gate_ctrl_tb.sv
`timescale 1ns/1ps
module irq_gate_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_done = 1'b0;
  logic       op_ei = 1'b0;
  logic       op_di = 1'b0;
  logic       op_halt = 1'b0;
  logic       irq_req = 1'b0;
  logic       r_load = 1'b0;
  logic [7:0] r_wdata = 8'h00;
  logic       ien_master, ien_shadow, halted, fetch_inhibit, irq_accept, push_pc;
  logic [7:0] refresh;

  always #2 clk = ~clk;

  irq_gate_ctrl dut_i (
    .clk(clk), .rst(rst), .step_done(step_done), .op_ei(op_ei), .op_di(op_di),
    .op_halt(op_halt), .irq_req(irq_req), .r_load(r_load), .r_wdata(r_wdata),
    .ien_master(ien_master), .ien_shadow(ien_shadow), .halted(halted),
    .fetch_inhibit(fetch_inhibit), .irq_accept(irq_accept), .push_pc(push_pc),
    .refresh(refresh)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;
  string cur_tag = "R1";

  // Reference state
  bit       m_mst, m_shd, m_hlt, m_acc;
  int       m_cnt;
  bit [7:0] m_r;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] out_vec();
    return {ien_master, ien_shadow, halted, fetch_inhibit, irq_accept, push_pc, refresh};
  endfunction

  function automatic logic [13:0] exp_vec();
    return {m_mst, m_shd, m_hlt, m_hlt, m_acc, m_acc, m_r};
  endfunction

  task automatic model_tick();
    bit exec, take, isdi, isei, ishl, expire;
    if (rst) begin
      m_mst = 0; m_shd = 0; m_hlt = 0; m_acc = 0; m_cnt = 0; m_r = 8'h00;
    end else begin
      m_acc = 0;
      if (step_done) begin
        exec   = !m_hlt;
        take   = irq_req && m_mst;
        isdi   = exec && op_di;
        isei   = exec && !op_di && op_ei;
        ishl   = exec && !op_di && !op_ei && op_halt;
        expire = 0;
        if (take || isdi) m_cnt = 0;
        else if (isei) m_cnt = 1;
        else if (m_cnt > 0) begin
          m_cnt--;
          if (m_cnt == 0) expire = 1;
        end
        if (take || isdi) begin m_mst = 0; m_shd = 0; end
        else if (expire) begin m_mst = 1; m_shd = 1; end
        if (irq_req) m_hlt = 0;
        else if (ishl) m_hlt = 1;
        if (exec && r_load) m_r = r_wdata;
        else m_r = {m_r[7], m_r[6:0] + 7'd1};
        m_acc = take;
      end
    end
  endtask

  // One clock: drive at negedge, model after the edge, compare at next negedge
  task automatic cyc(input bit s, input bit ei, input bit di, input bit hl,
                     input bit irq, input bit rl, input logic [7:0] rd, input bit r);
    rst = r; step_done = s; op_ei = ei; op_di = di; op_halt = hl;
    irq_req = irq; r_load = rl; r_wdata = rd;
    @(posedge clk);
    model_tick();
    @(negedge clk);
    check(cur_tag, 32'(out_vec()), 32'(exp_vec()));
  endtask

  task automatic step_op(input bit ei, input bit di, input bit hl, input bit irq);
    cyc(1, ei, di, hl, irq, 0, 8'h00, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    @(negedge clk);

    // R1, R11: reset held while a request and step are present
    cur_tag = "R11";
    cyc(1, 0, 0, 0, 1, 0, 8'h00, 1);
    cyc(1, 0, 0, 0, 1, 0, 8'h00, 1);
    check("R1", 32'(out_vec()), 32'h0);
    cur_tag = "R1";
    cyc(0, 0, 0, 0, 0, 0, 8'h00, 0);
    check("R1", 32'(ien_master), 32'h0);

    // R2: enable takes hold after the following step, idle cycles do not count
    cur_tag = "R2";
    step_op(1, 0, 0, 0);
    check("R2", 32'(ien_master), 32'h0);
    cyc(0, 0, 0, 0, 0, 0, 8'h00, 0);
    cyc(0, 0, 0, 0, 0, 0, 8'h00, 0);
    check("R2", 32'(ien_master), 32'h0);
    step_op(0, 0, 0, 0);
    check("R2", 32'({ien_master, ien_shadow}), 32'h3);

    // R10: request without step strobe is ignored
    cur_tag = "R10";
    cyc(0, 0, 0, 0, 1, 0, 8'h00, 0);
    check("R10", 32'({irq_accept, ien_master}), 32'h1);

    // R3: disable clears at once, and cancels a pending enable
    cur_tag = "R3";
    step_op(0, 1, 0, 0);
    check("R3", 32'(ien_master), 32'h0);
    step_op(1, 0, 0, 0);
    step_op(0, 1, 0, 0);
    step_op(0, 0, 0, 0);
    step_op(0, 0, 0, 0);
    check("R3", 32'(ien_master), 32'h0);

    // R4, R6, R7: masked sleep, ops ignored, request wakes without accept
    cur_tag = "R4";
    step_op(0, 0, 1, 0);
    check("R4", 32'({halted, fetch_inhibit}), 32'h3);
    step_op(1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 1, 8'h80, 0);
    step_op(0, 0, 0, 0);
    check("R4", 32'({ien_master, halted, refresh[7]}), 32'h2);
    cur_tag = "R6";
    step_op(0, 0, 0, 1);
    check("R6", 32'(halted), 32'h0);
    check("R7", 32'({irq_accept, ien_master}), 32'h0);

    // R5: enable then halt, flags rise at the halt boundary while sleeping
    cur_tag = "R5";
    step_op(1, 0, 0, 0);
    step_op(0, 0, 1, 0);
    check("R5", 32'({ien_master, halted}), 32'h3);

    // R8: enabled request while halted is accepted, pulse lasts one clock
    cur_tag = "R8";
    step_op(0, 0, 0, 1);
    check("R8", 32'({irq_accept, push_pc, ien_master, ien_shadow, halted}), 32'h18);
    step_op(0, 0, 0, 1);
    check("R8", 32'(irq_accept), 32'h0);

    // R2 with R8: expiry and request on one boundary, taken one step later
    cur_tag = "R2";
    step_op(1, 0, 0, 0);
    step_op(0, 0, 0, 1);
    check("R2", 32'({ien_master, irq_accept}), 32'h2);
    step_op(0, 0, 0, 1);
    check("R8", 32'({ien_master, irq_accept}), 32'h1);

    // R6: halt step and request on one boundary stays awake
    cur_tag = "R6";
    step_op(0, 0, 1, 1);
    check("R6", 32'(halted), 32'h0);

    // R9: refresh wrap keeps bit 7
    cur_tag = "R9";
    cyc(1, 0, 0, 0, 0, 1, 8'hFF, 0);
    check("R9", 32'(refresh), 32'hFF);
    step_op(0, 0, 0, 0);
    check("R9", 32'(refresh), 32'h80);
    cyc(1, 0, 0, 0, 0, 1, 8'h7F, 0);
    step_op(0, 0, 0, 0);
    check("R9", 32'(refresh), 32'h00);

    // R11: reset against a request while enabled
    cur_tag = "R11";
    step_op(1, 0, 0, 0);
    step_op(0, 0, 0, 0);
    cyc(1, 0, 0, 0, 1, 0, 8'h00, 1);
    check("R11", 32'({irq_accept, ien_master}), 32'h0);

    // Random mix judged by the model
    cur_tag = "RND";
    for (int i = 0; i < 4000; i++) begin
      int sel;
      bit s, ei, di, hl;
      sel = $urandom_range(0, 7);
      s  = ($urandom_range(0, 2) != 0);
      ei = (sel == 1) || (sel == 2);
      di = (sel == 3);
      hl = (sel == 4);
      cyc(s, ei, di, hl, ($urandom_range(0, 3) == 0), ($urandom_range(0, 9) == 0),
          8'($urandom_range(0, 255)), ($urandom_range(0, 199) == 0));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule